// File: doc/BRIEF.md
# Orthogonal Latin Square Check-Bit Encoder

This block produces the check bits of an orthogonal Latin square error-correcting code for one data word. Think of the data word as an M×M array. Each check bit is the XOR of M data bits, and those M bits form one cell class of a partition of the array. The first partition is by array row and the second is by array column. Each further partition takes the symbol classes of one Latin square in a mutually orthogonal family. With correction capability T there are 2T partitions, so the block emits 2·T·M check bits for M² data bits.

Every data bit lies in exactly 2T parity equations, and no two of those equations share any other data bit. This property is what allows a decoder to recover each bit in one step by majority vote.

The block has no state of its own. A parameter can add one register stage on the output. That register clears when reset is asserted, which is active low. With the default parameters (M=5, T=2, no output register) the block maps 25 data bits to 20 check bits in pure combinational logic.

Top module: `ols_encoder`

## Requirements
- R1: An all-zero data word gives an all-zero check word.
- R2: Check bit j, for 0 ≤ j < M, is the XOR of data bits j·M through j·M+M−1. These are the row parities, and data bit i sits at row r = i / M and column c = i % M.
- R3: Check bit M+j is the XOR of every data bit whose column c equals j.
- R4: For square k, with 1 ≤ k ≤ 2T−2, check bit (k+1)·M+s is the XOR of every data bit with (r + k·c) mod M = s. M is prime and 2T−1 ≤ M.
- R5: A data word with exactly one bit set gives exactly 2T set check bits, one in each block of M check bits.
- R6: Any two distinct data bits share at most one check equation, so a word with exactly two bits set gives at least 4T−2 set check bits.
- R7: The encoding is linear: the check word of a XOR b equals the check word of a XOR the check word of b.
- R8: Within every block of M check bits, the XOR of the block equals the XOR of the whole data word.
- R9: With PIPE=0 the check word follows data_in in the same cycle. With PIPE=1 the check word appears one clock after the data and is all zero while rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset for the output register |
| data_in | input | M*M | Data word to encode |
| check_out | output | 2*T*M | Check word: rows, then columns, then one block per square |

## Verification
Suppose one parity lane selects the wrong data bits. A walking single-one pattern then shows it on the very vector that drives a misrouted bit. The check word has the wrong weight, or two bits set in one block, and the per-block XOR no longer matches the XOR of the data. Two-hot patterns show whether two equations overlap, because any overlap drops the check weight below 4T−2. For the registered variant, the check word must lag data_in by exactly one clock and must read zero throughout reset. An error in either shows up within one cycle.

// File: rtl/ols_pkg.sv
package ols_pkg;

    // Group 0: rows, group 1: columns, group g>=2: square k=g-1.
    function automatic bit in_lane(input int m, input int g, input int j, input int i);
        int r;
        int c;
        r = i / m;
        c = i % m;
        if (g == 0)
            return (r == j);
        else if (g == 1)
            return (c == j);
        else
            return (((r + (g - 1) * c) % m) == j);
    endfunction

endpackage

// File: rtl/ols_lane.sv
module ols_lane #(
    parameter int M = 5,
    parameter int G = 0,
    parameter int J = 0
) (
    input  logic [M*M-1:0] data,
    output logic           parity
);
    localparam int N = M * M;

    always_comb begin
        parity = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ols_pkg::in_lane(M, G, J, i))
                parity = parity ^ data[i];
        end
    end
endmodule

// File: rtl/ols_group.sv
module ols_group #(
    parameter int M = 5,
    parameter int G = 0
) (
    input  logic [M*M-1:0] data,
    output logic [M-1:0]   par
);
    for (genvar j = 0; j < M; j++) begin : g_lane
        ols_lane #(.M(M), .G(G), .J(j)) u_lane (
            .data   (data),
            .parity (par[j])
        );
    end
endmodule

// File: rtl/ols_encoder.sv
module ols_encoder #(
    parameter int M    = 5,
    parameter int T    = 2,
    parameter bit PIPE = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [M*M-1:0]       data_in,
    output logic [2*T*M-1:0]     check_out
);
    localparam int N      = M * M;
    localparam int GROUPS = 2 * T;
    localparam int C      = GROUPS * M;

    logic [C-1:0] chk_comb;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        ols_group #(.M(M), .G(g)) u_grp (
            .data (data_in),
            .par  (chk_comb[g*M +: M])
        );

        AST_GROUP_XOR: assert property (@(posedge clk) disable iff (!rst_n)
            (^chk_comb[g*M +: M]) == (^data_in)); // R8
        AST_ONE_PER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
            ($countones(data_in) == 1) |-> ($countones(chk_comb[g*M +: M]) == 1)); // R5
    end

    if (PIPE) begin : g_reg
        logic [C-1:0] chk_q;
        logic         primed;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chk_q  <= '0;
                primed <= 1'b0;
            end else begin
                chk_q  <= chk_comb;
                primed <= 1'b1;
            end
        end
        assign check_out = chk_q;

        AST_PIPE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> (check_out == $past(chk_comb))); // R9
    end else begin : g_comb
        assign check_out = chk_comb;
    end

    AST_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (data_in == '0) |-> (chk_comb == '0)); // R1
    AST_BIT_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(data_in) == 1) |-> ($countones(chk_comb) == GROUPS)); // R5
    AST_PAIR_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(data_in) == 2) |-> ($countones(chk_comb) >= 2*GROUPS-2)); // R6

    logic unused_n;
    assign unused_n = ^{N[0], C[0]};
endmodule

// File: tb/ols_encoder_tb.sv
module ols_encoder_tb;
    localparam int M = 5;
    localparam int T = 2;
    localparam int N = M * M;
    localparam int C = 2 * T * M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] data_in = '0;
    logic [C-1:0] chk_c;
    logic [C-1:0] chk_r;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ols_encoder #(.M(M), .T(T), .PIPE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .check_out(chk_c));
    ols_encoder #(.M(M), .T(T), .PIPE(1'b1)) u_dut_reg (
        .clk(clk), .rst_n(rst_n), .data_in(data_in), .check_out(chk_r));

    // Reference: scatter each set data bit into its 2T equations.
    function automatic logic [C-1:0] ref_chk(input logic [N-1:0] d);
        logic [C-1:0] v;
        int r;
        int c;
        v = '0;
        for (int i = 0; i < N; i++) begin
            if (d[i]) begin
                r = i / M;
                c = i % M;
                v[r]     = ~v[r];
                v[M + c] = ~v[M + c];
                for (int k = 1; k <= 2*T-2; k++)
                    v[(k+1)*M + (r + k*c) % M] = ~v[(k+1)*M + (r + k*c) % M];
            end
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] d, input string tag);
        logic [C-1:0] prev;
        logic [C-1:0] e;
        prev = ref_chk(data_in);
        e = ref_chk(d);
        @(negedge clk);
        data_in = d;
        #1;
        check(chk_c == e, tag, 64'(chk_c), 64'(e));
        check(chk_r == prev, "R9 register holds before edge", 64'(chk_r), 64'(prev));
        @(negedge clk);
        check(chk_r == e, "R9 register one cycle later", 64'(chk_r), 64'(e));
    endtask

    initial begin
        #(8 * 190000);
        check(1'b0, "watchdog expired", 64'(0), 64'(1));
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0] a;
        logic [N-1:0] b;
        logic [C-1:0] ca;
        logic [C-1:0] cb;
        data_in = '1;
        repeat (3) @(negedge clk);
        #1;
        check(chk_r == '0, "R9 reset clears register", 64'(chk_r), 64'(0));
        check(chk_c == ref_chk('1), "R9 comb path live in reset", 64'(chk_c), 64'(ref_chk('1)));
        rst_n = 1'b1;

        apply('0, "R1 zero data");
        check(chk_c == '0, "R1 zero check word", 64'(chk_c), 64'(0));
        apply('1, "R2 R3 R4 all ones");
        check(chk_c == '1, "R8 all-ones gives odd blocks", 64'(chk_c), 64'({C{1'b1}}));

        for (int r = 0; r < M; r++) begin
            apply(N'({M{1'b1}}) << (r*M), "R2 full row");
            check(chk_c[M-1:0] == M'(1 << r), "R2 row lane", 64'(chk_c[M-1:0]), 64'(1 << r));
        end

        for (int i = 0; i < N; i++) begin
            apply(N'(1) << i, "R3 R4 walking one");
            check($countones(chk_c) == 2*T, "R5 weight", 64'($countones(chk_c)), 64'(2*T));
            for (int g = 0; g < 2*T; g++)
                check($countones(chk_c[g*M +: M]) == 1, "R5 one per block",
                      64'($countones(chk_c[g*M +: M])), 64'(1));
        end

        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                apply((N'(1) << i) | (N'(1) << j), "R6 two-hot");
                check($countones(chk_c) >= 4*T-2, "R6 overlap",
                      64'($countones(chk_c)), 64'(4*T-2));
            end
        end

        for (int n = 0; n < 300; n++) begin
            a = N'($urandom);
            b = N'($urandom);
            apply(a, "R4 random a");
            ca = chk_c;
            for (int g = 0; g < 2*T; g++)
                check((^chk_c[g*M +: M]) == (^a), "R8 block xor",
                      64'(^chk_c[g*M +: M]), 64'(^a));
            apply(b, "R4 random b");
            cb = chk_c;
            apply(a ^ b, "R7 random a^b");
            check(chk_c == (ca ^ cb), "R7 linearity", 64'(chk_c), 64'(ca ^ cb));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule